// File: doc/BRIEF.md
# Dual-Accumulator Multiply-Accumulate Engine

This block is the arithmetic core of a signal-processing datapath. Each cycle it can accept one operation on two 16-bit operands. It forms a product with a 17x17 signed multiplier and combines that product, or the other accumulator, with the chosen 40-bit accumulator in a 41-bit adder/subtracter. The result is then saturated and written back. Two accumulators are kept. Each has its own saturation enable and its own overflow flags.

Mode inputs set how the operation behaves:
- whether operands are treated as signed or unsigned;
- whether the product is fractional (1.15 x 1.15 aligned as 1.31) or integer;
- whether accumulator saturation clamps at the 32-bit boundary or the 40-bit boundary.

A separate read port always presents a 16-bit word taken from either accumulator. That word is rounded (conventional or round-half-to-even) and can optionally be clamped to the 16-bit range. It is meant for storing an accumulator to memory.

Top module: `dmac_engine`

## Requirements
- R1: After reset both accumulators are zero and all four overflow flags are clear.
- R2: With signed_mode high the operands are sign-extended to 17 bits, and with it low they are zero-extended. The squared-difference operations always take the difference of the sign-extended operands.
- R3: With frac_mode high the product is doubled (shifted left by one) before it is used. With it low the product is used as is.
- R4: op_code selects the result written to accumulator T (acc_sel 0 = A, 1 = B). The codes are: 0 clear; 1 (x-y)^2; 2 T+(x-y)^2; 3 T+x*y; 4 T+x^2; 5 x*y; 6 x^2; 7 -x*y; 8 T-x*y; 9 T unchanged. Codes 13 to 15 change nothing, and neither do the flags.
- R5: Code 10 writes T+O, code 11 writes T-O and code 12 writes -T, where O is the other accumulator. These codes ignore x and y.
- R6: An accumulator changes only when op_valid is high and acc_sel names it.
- R7: When saturation for T is enabled and sat_wide is low, a result outside the signed 32-bit range is clamped to 0x007FFFFFFF or 0xFF80000000.
- R8: When saturation for T is enabled and sat_wide is high, a result outside the signed 40-bit range is clamped to 0x7FFFFFFFFF or 0x8000000000.
- R9: When saturation for T is disabled, the result wraps modulo 2^40.
- R10: Every writing operation (codes 0 to 8 and 10 to 12) sets T's narrow flag if the unsaturated result lies outside the signed 32-bit range, and sets T's wide flag if it lies outside the signed 40-bit range. Saturation does not affect this. Each flag is cleared otherwise. Flags are held on codes 9 and 13 to 15. Bit 0 of each flag vector belongs to A and bit 1 to B.
- R11: store_word is bits 31:16 of the accumulator chosen by store_sel after 0x8000 has been added (conventional rounding, round_convergent low).
- R12: With round_convergent high, an accumulator whose low 16 bits are exactly 0x8000 rounds up only if bit 16 is 1. All other values round as in R11.
- R13: With store_sat_en high, a rounded value above 0x7FFFFFFF gives 0x7FFF and one below -2^31 gives 0x8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Execute op_code this cycle |
| op_code | input | 4 | Operation code (see R4, R5) |
| acc_sel | input | 1 | Target accumulator: 0 = A, 1 = B |
| x_in | input | 16 | First operand |
| y_in | input | 16 | Second operand |
| frac_mode | input | 1 | Fractional product alignment |
| signed_mode | input | 1 | Signed operand extension |
| round_convergent | input | 1 | Round-half-to-even on the store word |
| sat_a_en | input | 1 | Saturation enable for A |
| sat_b_en | input | 1 | Saturation enable for B |
| sat_wide | input | 1 | Clamp at 40 bits instead of 32 |
| store_sat_en | input | 1 | Clamp the store word to 16 bits |
| store_sel | input | 1 | Accumulator presented on store_word |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| ovf_narrow | output | 2 | 32-bit overflow flags {B, A} |
| ovf_wide | output | 2 | 40-bit overflow flags {B, A} |
| store_word | output | 16 | Rounded, optionally saturated store word |

## Verification
Two pairs of functions can act in the same cycle.

The first pair is the overflow flagging and the accumulator clamp. A long run of fractional -1 x -1 accumulations crosses the 32-bit boundary and then the 40-bit boundary. This run is repeated with saturation off, with narrow saturation and with wide saturation. The flag must report the unsaturated sum even when the written value has been clamped.

The second pair is the rounding carry and the store clamp. The accumulator is loaded with 0x7FFF8000 so that rounding carries into bit 31. The test then checks that the store clamp yields 0x7FFF while the unclamped word wraps to 0x8000. A sweep over every code, both targets and a set of edge operands, with the modes varied, compares every output with arithmetic done in the bench.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    typedef enum logic [3:0] {
        OP_CLR       = 4'd0,
        OP_SQD       = 4'd1,
        OP_SQD_ACC   = 4'd2,
        OP_MAC       = 4'd3,
        OP_SQR_ACC   = 4'd4,
        OP_MPY       = 4'd5,
        OP_SQR       = 4'd6,
        OP_NMPY      = 4'd7,
        OP_MSUB      = 4'd8,
        OP_HOLD      = 4'd9,
        OP_ADD_OTHER = 4'd10,
        OP_SUB_OTHER = 4'd11,
        OP_NEGATE    = 4'd12
    } op_e;

    typedef enum logic [1:0] {
        SRC_XY = 2'd0,
        SRC_XX = 2'd1,
        SRC_DD = 2'd2
    } msrc_e;
endpackage

// File: rtl/dmac_mul.sv
module dmac_mul #(
    parameter int DW = 16,
    localparam int PW = DW + 1,
    localparam int PRODW = 2 * PW + 1
) (
    input  logic [DW-1:0]           x_in,
    input  logic [DW-1:0]           y_in,
    input  logic                    signed_mode,
    input  logic                    frac_mode,
    input  dmac_pkg::msrc_e         src,
    output logic signed [PRODW-1:0] prod
);
    logic signed [PW-1:0]     xe, ye, dif, ma, mb;
    logic signed [2*PW-1:0]   raw;

    always_comb begin
        xe  = signed_mode ? {x_in[DW-1], x_in} : {1'b0, x_in};
        ye  = signed_mode ? {y_in[DW-1], y_in} : {1'b0, y_in};
        dif = $signed({x_in[DW-1], x_in}) - $signed({y_in[DW-1], y_in});
        case (src)
            dmac_pkg::SRC_XX: begin ma = xe;  mb = xe;  end
            dmac_pkg::SRC_DD: begin ma = dif; mb = dif; end
            default:          begin ma = xe;  mb = ye;  end
        endcase
        raw  = ma * mb;
        prod = frac_mode ? {raw, 1'b0} : {raw[2*PW-1], raw};
    end
endmodule

// File: rtl/dmac_sat.sv
module dmac_sat #(
    parameter int AW = 40,
    parameter int NB = 32
) (
    input  logic signed [AW:0] sum,
    input  logic               sat_en,
    input  logic               wide,
    output logic [AW-1:0]      res,
    output logic               ovf_n,
    output logic               ovf_w
);
    always_comb begin
        ovf_w = sum[AW] ^ sum[AW-1];
        ovf_n = !((&sum[AW:NB-1]) || !(|sum[AW:NB-1]));
        if (sat_en && wide && ovf_w)
            res = sum[AW] ? {1'b1, {(AW-1){1'b0}}} : {1'b0, {(AW-1){1'b1}}};
        else if (sat_en && !wide && ovf_n)
            res = sum[AW] ? {{(AW-NB+1){1'b1}}, {(NB-1){1'b0}}}
                          : {{(AW-NB+1){1'b0}}, {(NB-1){1'b1}}};
        else
            res = sum[AW-1:0];
    end
endmodule

// File: rtl/dmac_round.sv
module dmac_round #(
    parameter int AW = 40,
    parameter int DW = 16,
    localparam int NB = 2 * DW
) (
    input  logic [AW-1:0] acc,
    input  logic          convergent,
    input  logic          sat_en,
    output logic [DW-1:0] word
);
    logic          tie, bump, hi_bad;
    logic [AW:0]   r;

    always_comb begin
        tie    = (acc[DW-1:0] == {1'b1, {(DW-1){1'b0}}});
        bump   = !(convergent && tie && !acc[DW]);
        r      = {acc[AW-1], acc} + (bump ? (AW+1)'(1 << (DW-1)) : '0);
        hi_bad = !((&r[AW:NB-1]) || !(|r[AW:NB-1]));
        if (sat_en && hi_bad)
            word = r[AW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
        else
            word = r[NB-1:DW];
    end
endmodule

// File: rtl/dmac_engine.sv
module dmac_engine #(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [3:0]    op_code,
    input  logic          acc_sel,
    input  logic [DW-1:0] x_in,
    input  logic [DW-1:0] y_in,
    input  logic          frac_mode,
    input  logic          signed_mode,
    input  logic          round_convergent,
    input  logic          sat_a_en,
    input  logic          sat_b_en,
    input  logic          sat_wide,
    input  logic          store_sat_en,
    input  logic          store_sel,
    output logic [AW-1:0] acc_a,
    output logic [AW-1:0] acc_b,
    output logic [1:0]    ovf_narrow,
    output logic [1:0]    ovf_wide,
    output logic [DW-1:0] store_word
);
    import dmac_pkg::*;

    localparam int PRODW = 2 * (DW + 1) + 1;
    localparam int SW    = AW + 1;
    localparam int NB    = 2 * DW;

    typedef struct packed {
        logic [1:0][AW-1:0] acc;
        logic [1:0]         ovf_n;
        logic [1:0]         ovf_w;
    } state_t;

    state_t st_d, st_q;

    msrc_e                  msrc;
    logic signed [PRODW-1:0] prod;
    logic signed [SW-1:0]   tgt_x, oth_x, prod_x, base, addend, sum_d;
    logic                   sub_d, wr_d, sat_sel;
    logic [AW-1:0]          sat_res;
    logic                   sat_ovf_n, sat_ovf_w;
    logic [1:0][DW-1:0]     rnd_word;

    always_comb begin
        case (op_e'(op_code))
            OP_SQD, OP_SQD_ACC: msrc = SRC_DD;
            OP_SQR, OP_SQR_ACC: msrc = SRC_XX;
            default:            msrc = SRC_XY;
        endcase
    end

    dmac_mul #(.DW(DW)) u_mul (
        .x_in(x_in), .y_in(y_in), .signed_mode(signed_mode),
        .frac_mode(frac_mode), .src(msrc), .prod(prod)
    );

    always_comb begin
        tgt_x  = {st_q.acc[acc_sel][AW-1], st_q.acc[acc_sel]};
        oth_x  = {st_q.acc[~acc_sel][AW-1], st_q.acc[~acc_sel]};
        prod_x = {{(SW-PRODW){prod[PRODW-1]}}, prod};
        base   = '0;
        addend = '0;
        sub_d  = 1'b0;
        wr_d   = 1'b1;
        case (op_e'(op_code))
            OP_CLR:       ;
            OP_SQD:       addend = prod_x;
            OP_SQD_ACC:   begin base = tgt_x; addend = prod_x; end
            OP_MAC:       begin base = tgt_x; addend = prod_x; end
            OP_SQR_ACC:   begin base = tgt_x; addend = prod_x; end
            OP_MPY:       addend = prod_x;
            OP_SQR:       addend = prod_x;
            OP_NMPY:      begin addend = prod_x; sub_d = 1'b1; end
            OP_MSUB:      begin base = tgt_x; addend = prod_x; sub_d = 1'b1; end
            OP_ADD_OTHER: begin base = tgt_x; addend = oth_x; end
            OP_SUB_OTHER: begin base = tgt_x; addend = oth_x; sub_d = 1'b1; end
            OP_NEGATE:    begin addend = tgt_x; sub_d = 1'b1; end
            default:      wr_d = 1'b0;
        endcase
        sum_d   = sub_d ? (base - addend) : (base + addend);
        sat_sel = acc_sel ? sat_b_en : sat_a_en;
    end

    dmac_sat #(.AW(AW), .NB(NB)) u_sat (
        .sum(sum_d), .sat_en(sat_sel), .wide(sat_wide),
        .res(sat_res), .ovf_n(sat_ovf_n), .ovf_w(sat_ovf_w)
    );

    always_comb begin
        st_d = st_q;
        if (op_valid && wr_d) begin
            st_d.acc[acc_sel]   = sat_res;
            st_d.ovf_n[acc_sel] = sat_ovf_n;
            st_d.ovf_w[acc_sel] = sat_ovf_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < 2; g++) begin : g_rnd
        dmac_round #(.AW(AW), .DW(DW)) u_rnd (
            .acc(st_q.acc[g]), .convergent(round_convergent),
            .sat_en(store_sat_en), .word(rnd_word[g])
        );
    end

    assign acc_a      = st_q.acc[0];
    assign acc_b      = st_q.acc[1];
    assign ovf_narrow = st_q.ovf_n;
    assign ovf_wide   = st_q.ovf_w;
    assign store_word = rnd_word[store_sel];
endmodule

// File: rtl/dmac_engine_chk.sv
module dmac_engine_chk #(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [3:0]    op_code,
    input logic          acc_sel,
    input logic          sat_a_en,
    input logic          sat_wide,
    input logic          store_sat_en,
    input logic          store_sel,
    input logic [AW-1:0] acc_a,
    input logic [AW-1:0] acc_b,
    input logic [1:0]    ovf_narrow,
    input logic [1:0]    ovf_wide,
    input logic [DW-1:0] store_word
);
    localparam int NB = 2 * DW;

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (acc_a == $past(acc_a)) && (acc_b == $past(acc_b)));

    a_r6_b_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !acc_sel |=> acc_b == $past(acc_b));

    a_r6_a_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && acc_sel |=> acc_a == $past(acc_a));

    a_r4_clear_a: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !acc_sel && op_code == 4'd0 |=> acc_a == '0 && !ovf_wide[0]);

    a_r7_narrow_range: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !acc_sel && sat_a_en && !sat_wide && op_code <= 4'd12 && op_code != 4'd9
        |=> ((&acc_a[AW-1:NB-1]) || !(|acc_a[AW-1:NB-1])) && !ovf_wide[0] || ovf_narrow[0]);

    a_r10_flags_held: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code >= 4'd13 |=> $stable(ovf_narrow) && $stable(ovf_wide));

    a_r10_wide_implies_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_wide[0] |-> ovf_narrow[0]);

    a_r13_low_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        store_sat_en && !store_sel && acc_a[AW-1] && !(&acc_a[AW-1:NB-1])
        |-> store_word == {1'b1, {(DW-1){1'b0}}});
endmodule

bind dmac_engine dmac_engine_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .acc_sel(acc_sel), .sat_a_en(sat_a_en), .sat_wide(sat_wide),
    .store_sat_en(store_sat_en), .store_sel(store_sel), .acc_a(acc_a),
    .acc_b(acc_b), .ovf_narrow(ovf_narrow), .ovf_wide(ovf_wide),
    .store_word(store_word)
);

// File: tb/dmac_engine_bench.sv
`timescale 1ns/100ps
module dmac_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic        acc_sel = 1'b0;
    logic [15:0] x_in = '0, y_in = '0;
    logic        frac_mode = 0, signed_mode = 1, round_convergent = 0;
    logic        sat_a_en = 0, sat_b_en = 0, sat_wide = 0;
    logic        store_sat_en = 0, store_sel = 0;
    logic [39:0] acc_a, acc_b;
    logic [1:0]  ovf_narrow, ovf_wide;
    logic [15:0] store_word;

    int nchk = 0, nerr = 0;
    bit done = 0;
    longint m_acc [2];
    bit m_on [2];
    bit m_ow [2];

    localparam longint MAX40 = 64'sh7F_FFFF_FFFF;
    localparam longint MIN40 = -64'sh80_0000_0000;
    localparam longint MAX32 = 64'sh7FFF_FFFF;
    localparam longint MIN32 = -64'sh8000_0000;

    always #2.5 clk = ~clk;

    dmac_engine u_dmac_engine (.*);

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic longint wrap40(longint s);
        logic [63:0] v = s;
        return longint'($signed(v[39:0]));
    endfunction

    function automatic logic [15:0] exp_store(longint a);
        logic [63:0] av = a;
        logic [63:0] rv;
        longint r;
        bit add = !(round_convergent && av[15:0] == 16'h8000 && !av[16]);
        r = a + (add ? 64'sh8000 : 64'sh0);
        rv = r;
        if (store_sat_en && r > MAX32) return 16'h7FFF;
        if (store_sat_en && r < MIN32) return 16'h8000;
        return rv[31:16];
    endfunction

    function automatic void model(bit v, logic [3:0] op, bit sel, logic [15:0] x, logic [15:0] y);
        longint xs, ys, ds, p, sum;
        bit wr = 1, en;
        int t = sel, o = 1 - sel;
        xs = signed_mode ? longint'($signed(x)) : longint'(x);
        ys = signed_mode ? longint'($signed(y)) : longint'(y);
        ds = longint'($signed(x)) - longint'($signed(y));
        case (op)
            4'd1, 4'd2: p = ds * ds;
            4'd4, 4'd6: p = xs * xs;
            default:    p = xs * ys;
        endcase
        if (frac_mode) p = p * 2;
        case (op)
            4'd0:  sum = 0;
            4'd1, 4'd5, 4'd6: sum = p;
            4'd2, 4'd3, 4'd4: sum = m_acc[t] + p;
            4'd7:  sum = -p;
            4'd8:  sum = m_acc[t] - p;
            4'd10: sum = m_acc[t] + m_acc[o];
            4'd11: sum = m_acc[t] - m_acc[o];
            4'd12: sum = -m_acc[t];
            default: begin sum = 0; wr = 0; end
        endcase
        if (!v || !wr) return;
        en = sel ? sat_b_en : sat_a_en;
        m_ow[t] = (sum > MAX40) || (sum < MIN40);
        m_on[t] = (sum > MAX32) || (sum < MIN32);
        if (en && sat_wide && m_ow[t])       m_acc[t] = (sum > 0) ? MAX40 : MIN40;
        else if (en && !sat_wide && m_on[t]) m_acc[t] = (sum > 0) ? MAX32 : MIN32;
        else                                 m_acc[t] = wrap40(sum);
    endfunction

    task automatic compare(string tag);
        logic [63:0] ea = m_acc[0], eb = m_acc[1];
        chk(tag, "acc_a", acc_a, ea[39:0]);
        chk(tag, "acc_b", acc_b, eb[39:0]);
        chk("R10", "ovf_narrow", ovf_narrow, {m_on[1], m_on[0]});
        chk("R10", "ovf_wide", ovf_wide, {m_ow[1], m_ow[0]});
        chk(round_convergent ? "R12" : "R11", "store_word", store_word, exp_store(m_acc[store_sel]));
    endtask

    task automatic run(string tag, bit v, logic [3:0] op, bit sel, logic [15:0] x, logic [15:0] y);
        op_valid = v; op_code = op; acc_sel = sel; x_in = x; y_in = y;
        model(v, op, sel, x, y);
        @(negedge clk);
        op_valid = 1'b0;
        compare(tag);
    endtask

    function automatic string op_tag(logic [3:0] op);
        if (op >= 4'd10 && op <= 4'd12) return "R5";
        if (op == 4'd9) return "R6";
        return "R4";
    endfunction

    initial begin
        logic [15:0] vals [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                                  16'hFFFF, 16'h1234, 16'hA5A5, 16'h0100};
        logic [31:0] lcg = 32'h1;
        m_acc[0] = 0; m_acc[1] = 0; m_on = '{0, 0}; m_ow = '{0, 0};
        repeat (3) @(negedge clk);
        chk("R1", "acc_a in reset", acc_a, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "acc_b after reset", acc_b, 0);
        chk("R1", "flags after reset", {ovf_narrow, ovf_wide}, 0);

        // R2: operand extension
        signed_mode = 0; run("R2", 1, 4'd5, 0, 16'hFFFF, 16'h0002);
        chk("R2", "unsigned 0xFFFF*2", acc_a, 40'h1FFFE);
        signed_mode = 1; run("R2", 1, 4'd5, 0, 16'hFFFF, 16'h0002);
        chk("R2", "signed -1*2", acc_a, 40'hFFFFFFFFFE);
        signed_mode = 0; run("R2", 1, 4'd1, 1, 16'h0000, 16'hFFFF);
        chk("R2", "sqdiff uses signed diff", acc_b, 40'h1);
        signed_mode = 1;

        // R3: fractional alignment
        frac_mode = 1; run("R3", 1, 4'd5, 0, 16'h4000, 16'h4000);
        chk("R3", "0.5*0.5 frac", acc_a, 40'h0020000000);
        frac_mode = 0; run("R3", 1, 4'd5, 0, 16'h0003, 16'h0005);
        chk("R3", "3*5 int", acc_a, 40'h000000000F);

        // R7: narrow saturation with flag
        frac_mode = 1; sat_a_en = 1;
        run("R7", 1, 4'd5, 0, 16'h8000, 16'h8000);
        chk("R7", "narrow clamp", acc_a, 40'h007FFFFFFF);
        chk("R10", "narrow flag while clamped", ovf_narrow[0], 1);

        // R8, R9: long accumulation across the 40-bit boundary
        sat_b_en = 1; sat_wide = 1; run("R8", 1, 4'd0, 1, 0, 0);
        for (int i = 0; i < 300; i++) run("R8", 1, 4'd3, 1, 16'h8000, 16'h8000);
        chk("R8", "wide clamp", acc_b, 40'h7FFFFFFFFF);
        chk("R10", "wide flag B", ovf_wide[1], 1);
        sat_a_en = 0; run("R9", 1, 4'd0, 0, 0, 0);
        for (int i = 0; i < 300; i++) run("R9", 1, 4'd3, 0, 16'h8000, 16'h8000);
        chk("R9", "wrap mod 2^40", acc_a, 40'h9600000000);
        sat_wide = 0; sat_b_en = 0; frac_mode = 0;

        // R5: accumulator-to-accumulator
        run("R5", 1, 4'd5, 0, 16'h0010, 16'h0010);
        run("R5", 1, 4'd5, 1, 16'h0003, 16'h0001);
        run("R5", 1, 4'd10, 0, 16'hFFFF, 16'hFFFF);
        chk("R5", "A+B", acc_a, 40'h103);
        run("R5", 1, 4'd11, 1, 16'h1111, 16'h2222);
        chk("R5", "B-A", acc_b, 40'hFFFFFFFF00);
        run("R5", 1, 4'd12, 1, 0, 0);
        chk("R5", "-B", acc_b, 40'h100);

        // R6 and R4: no-change cases
        run("R6", 0, 4'd5, 0, 16'h7FFF, 16'h7FFF);
        chk("R6", "valid low ignored", acc_a, 40'h103);
        run("R4", 1, 4'd14, 0, 16'h7FFF, 16'h7FFF);
        chk("R4", "code 14 no effect", acc_a, 40'h103);

        // R12: convergent tie handling
        store_sel = 0; round_convergent = 1;
        run("R12", 1, 4'd5, 0, 16'h0080, 16'h0100);
        chk("R12", "even tie truncates", store_word, 16'h0000);
        round_convergent = 0; #0.5;
        chk("R11", "conventional tie rounds up", store_word, 16'h0001);
        round_convergent = 1;
        run("R12", 1, 4'd5, 0, 16'h0180, 16'h0100);
        chk("R12", "odd tie rounds up", store_word, 16'h0002);
        round_convergent = 0;

        // R13 with rounding carry into bit 31
        signed_mode = 0; store_sat_en = 1;
        run("R13", 1, 4'd5, 0, 16'hFFFF, 16'h8000);
        chk("R13", "rounded clamp high", store_word, 16'h7FFF);
        store_sat_en = 0; #0.5;
        chk("R11", "unclamped wraps", store_word, 16'h8000);
        signed_mode = 1;

        // Sweep over codes, targets, edge operands and modes
        for (int pass = 0; pass < 4; pass++)
            for (int op = 0; op < 16; op++)
                for (int s = 0; s < 2; s++)
                    for (int xi = 0; xi < 8; xi++)
                        for (int yi = 0; yi < 8; yi++) begin
                            lcg = lcg * 32'd1664525 + 32'd1013904223;
                            frac_mode = lcg[24]; signed_mode = lcg[25];
                            sat_a_en = lcg[26]; sat_b_en = lcg[27];
                            sat_wide = lcg[28]; round_convergent = lcg[29];
                            store_sat_en = lcg[30]; store_sel = lcg[31];
                            run(op_tag(op[3:0]), 1, op[3:0], s[0], vals[xi], vals[yi]);
                        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule